// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It does not look up one counter per branch address. It first reads a shift register that holds the recent taken/not-taken outcomes. That history is joined with low branch-address bits to select one small saturating counter in a pattern table. The counter's upper half means "taken". Four parameters size the block: the history-select address bits (a), the history length (k), the counter-select address bits (m) and the counter width (n). With a = 0, every branch shares a single history register. With a > 0, address bits select one of 2^a history registers, so each branch mostly sees its own past. A build option replaces the concatenated index with an XOR of the history and the address bits.

Fetch presents a PC on the predict port. In the same cycle the block returns a direction and the history snapshot that formed the index. When the branch resolves, the pipeline returns that PC, the real outcome and the saved snapshot on the update port. The block then trains the counter chosen by the snapshot. It also rewrites the selected history register as the snapshot shifted by one place with the outcome added, which repairs any history drift. Storage is k·2^a history bits plus 2^(index width)·n counter bits.

Top module: `bp_corr_top`

## Requirements
- R1: After reset every history register reads all zeros, and every counter holds 2^(n-1)-1 (weakly not taken), so pred_taken is 0 and pred_hist is 0 for any PC.
- R2: pred_taken is 1 exactly when the selected counter is at least 2^(n-1).
- R3: On an update, the selected counter goes up by one on taken and down by one on not taken. It stays at 2^n-1 on taken and at 0 on not taken.
- R4: With n = 2, a counter saturated at 3 still predicts taken after one not-taken update, and predicts not taken only after a second one.
- R5: On an update, the history register selected by upd_pc becomes the k low bits of {upd_hist, upd_taken}. Bit 0 is the newest outcome (1 = taken). pred_hist shows this register for pred_pc.
- R6: An update changes only the one counter addressed by (upd_pc, upd_hist). The counters of other history contexts for the same PC keep their values.
- R7: With a > 0, the history register is chosen by pc[2+a-1:2]. Updates for one such value leave the history seen by every other value unchanged.
- R8: With a = 0, one history register is shared, so an update by any PC changes the history seen for every PC.
- R9: In concatenated mode, the counter index is {history, pc[2+m-1:2]}. In hashed mode it is history XOR pc[2+m-1:2], both zero-extended to max(k,m) bits.
- R10: pred_taken and pred_hist are combinational from stored state. An update written at a clock edge is first visible after that edge, never in the same cycle.
- R11: While upd_valid is 0, no counter and no history register changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_LEN | History snapshot used for this prediction |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_LEN | Snapshot returned at prediction time |

## Verification
The bench drives two builds with the same stimulus: per-address history with a concatenated index, and one global history with the hashed index. A reference model checks each build at every step. It drives a loop-like branch into saturation and then sends not-taken outcomes. A design without saturation would wrap to 0 and predict not taken too early, and a one-bit scheme would flip after the first miss. Updates on a branch with different address bits catch designs that share or cross-wire history registers: the other branch's prediction or snapshot would move. Predictions sampled in the cycle of a write to the same index expose a design that forwards the write. Cycles with the strobe low, carrying taken outcomes, catch any write that ignores the strobe.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // PCs are word aligned; index bits start above the byte offset.
  localparam int unsigned WORD_OFS = 2;

  function automatic int unsigned max_u(input int unsigned x, input int unsigned y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned HIST_LEN = 2,
  parameter int unsigned PC_BITS  = 2,
  parameter bit          HASH_IDX = 1'b0,
  localparam int unsigned IDX_W   = HASH_IDX ? bp_pkg::max_u(HIST_LEN, PC_BITS)
                                             : HIST_LEN + PC_BITS
) (
  input  logic [PC_W-1:0]     pc,
  input  logic [HIST_LEN-1:0] hist,
  output logic [IDX_W-1:0]    idx
);
  logic [PC_BITS-1:0] pc_sel;
  assign pc_sel = pc[bp_pkg::WORD_OFS +: PC_BITS];

  generate
    if (HASH_IDX) begin : g_hash
      logic [IDX_W-1:0] h_ext, p_ext;
      always_comb begin
        h_ext = '0;
        p_ext = '0;
        h_ext[HIST_LEN-1:0] = hist;
        p_ext[PC_BITS-1:0]  = pc_sel;
        idx = h_ext ^ p_ext;
      end
    end else begin : g_concat
      assign idx = {hist, pc_sel};
    end
  endgenerate
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned SEL_BITS = 2,
  parameter int unsigned HIST_LEN = 2,
  localparam int unsigned NUM_REG = 1 << SEL_BITS,
  localparam int unsigned SEL_W   = (SEL_BITS > 0) ? SEL_BITS : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     rd_pc,
  output logic [HIST_LEN-1:0] rd_hist,
  input  logic                wr_en,
  input  logic [PC_W-1:0]     wr_pc,
  input  logic [HIST_LEN-1:0] wr_snap,
  input  logic                wr_taken
);
  logic [HIST_LEN-1:0] hist_q [NUM_REG];
  logic [HIST_LEN-1:0] hist_d [NUM_REG];
  logic [SEL_W-1:0]    rd_sel, wr_sel;
  logic [HIST_LEN:0]   shifted;

  generate
    if (SEL_BITS > 0) begin : g_per_addr
      assign rd_sel = rd_pc[bp_pkg::WORD_OFS +: SEL_W];
      assign wr_sel = wr_pc[bp_pkg::WORD_OFS +: SEL_W];
    end else begin : g_global
      assign rd_sel = '0;
      assign wr_sel = '0;
    end
  endgenerate

  assign shifted = {wr_snap, wr_taken};
  assign rd_hist = hist_q[rd_sel];

  always_comb begin
    for (int i = 0; i < NUM_REG; i++) hist_d[i] = hist_q[i];
    if (wr_en) hist_d[wr_sel] = shifted[HIST_LEN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REG; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REG; i++) hist_q[i] <= hist_d[i];
    end
  end

  // R5: the written register holds the snapshot shifted with the outcome
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hist_q[$past(wr_sel)] == $past(shifted[HIST_LEN-1:0]));

  // R11: no history change without the strobe
  assert_hist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> hist_q[0] == $past(hist_q[0]));
endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned CTR_BITS = 2,
  localparam int unsigned DEPTH   = 1 << IDX_W,
  localparam logic [CTR_BITS-1:0] CTR_MAX = '1,
  localparam logic [CTR_BITS-1:0] WEAK_NT = CTR_MAX >> 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  logic [DEPTH*CTR_BITS-1:0] ctr_q, ctr_d;
  logic [CTR_BITS-1:0]       rd_ctr, wr_cur, wr_nxt;

  assign rd_ctr   = ctr_q[rd_idx*CTR_BITS +: CTR_BITS];
  assign rd_taken = rd_ctr[CTR_BITS-1];
  assign wr_cur   = ctr_q[wr_idx*CTR_BITS +: CTR_BITS];

  always_comb begin
    wr_nxt = wr_cur;
    if (wr_taken && wr_cur != CTR_MAX) wr_nxt = wr_cur + 1'b1;
    else if (!wr_taken && wr_cur != '0) wr_nxt = wr_cur - 1'b1;
    ctr_d = ctr_q;
    if (wr_en) ctr_d[wr_idx*CTR_BITS +: CTR_BITS] = wr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctr_q <= {DEPTH{WEAK_NT}};
    else if (wr_en) ctr_q <= ctr_d;
  end

  // R3: saturation at the top
  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_cur == CTR_MAX)
      |=> ctr_q[$past(wr_idx)*CTR_BITS +: CTR_BITS] == CTR_MAX);

  // R3: saturation at the bottom
  assert_sat_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_cur == '0)
      |=> ctr_q[$past(wr_idx)*CTR_BITS +: CTR_BITS] == '0);

  // R11: table frozen while no update
  assert_pht_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctr_q));
endmodule

// File: rtl/bp_corr_top.sv
module bp_corr_top #(
  parameter int unsigned PC_W          = 32,
  parameter int unsigned HIST_SEL_BITS = 2,
  parameter int unsigned HIST_LEN      = 2,
  parameter int unsigned PC_IDX_BITS   = 2,
  parameter int unsigned CTR_BITS      = 2,
  parameter bit          HASH_IDX      = 1'b0,
  localparam int unsigned IDX_W = HASH_IDX ? bp_pkg::max_u(HIST_LEN, PC_IDX_BITS)
                                           : HIST_LEN + PC_IDX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     pred_pc,
  output logic                pred_taken,
  output logic [HIST_LEN-1:0] pred_hist,
  input  logic                upd_valid,
  input  logic [PC_W-1:0]     upd_pc,
  input  logic                upd_taken,
  input  logic [HIST_LEN-1:0] upd_hist
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [IDX_W-1:0] rd_idx, wr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bp_hist_table #(.PC_W(PC_W), .SEL_BITS(HIST_SEL_BITS), .HIST_LEN(HIST_LEN)) u_hist (
    .clk(clk), .rst_n(rst_int_n),
    .rd_pc(pred_pc), .rd_hist(pred_hist),
    .wr_en(upd_valid), .wr_pc(upd_pc), .wr_snap(upd_hist), .wr_taken(upd_taken)
  );

  bp_index #(.PC_W(PC_W), .HIST_LEN(HIST_LEN), .PC_BITS(PC_IDX_BITS),
             .HASH_IDX(HASH_IDX)) u_rd_idx (
    .pc(pred_pc), .hist(pred_hist), .idx(rd_idx)
  );

  bp_index #(.PC_W(PC_W), .HIST_LEN(HIST_LEN), .PC_BITS(PC_IDX_BITS),
             .HASH_IDX(HASH_IDX)) u_wr_idx (
    .pc(upd_pc), .hist(upd_hist), .idx(wr_idx)
  );

  bp_pht #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_pht (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(rd_idx), .rd_taken(pred_taken),
    .wr_en(upd_valid), .wr_idx(wr_idx), .wr_taken(upd_taken)
  );

  // R1: state is cleared while the internal reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!pred_taken && pred_hist == '0));
endmodule

// File: tb/bp_corr_top_tb_top.sv
module bp_corr_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pred_pc, upd_pc;
  logic        upd_valid, upd_taken;
  logic [1:0]  upd_hist_p, hist_p_o;
  logic [2:0]  upd_hist_g, hist_g_o;
  logic        taken_p_o, taken_g_o;

  // Per-address history (a=2,k=2,m=2,n=2), concatenated index
  bp_corr_top #(.HIST_SEL_BITS(2), .HIST_LEN(2), .PC_IDX_BITS(2), .CTR_BITS(2),
                .HASH_IDX(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(taken_p_o),
    .pred_hist(hist_p_o), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist_p));

  // Global history (a=0,k=3,m=2,n=2), hashed index
  bp_corr_top #(.HIST_SEL_BITS(0), .HIST_LEN(3), .PC_IDX_BITS(2), .CTR_BITS(2),
                .HASH_IDX(1'b1)) dut_g_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(taken_g_o),
    .pred_hist(hist_g_o), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist_g));

  // Reference model
  logic [1:0] m_hist_p [4];
  logic [1:0] m_ctr_p  [16];
  logic [2:0] m_hist_g;
  logic [1:0] m_ctr_g  [8];

  typedef struct {
    int         id;
    string      tag;
    logic       exp_t;
    logic [2:0] exp_h;
  } item_t;
  item_t sb_q[$];
  event  sample_ev;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t)  return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic step(input logic [31:0] ppc, input logic uv,
                      input logic [31:0] upc, input logic ut, input string tag);
    item_t it;
    logic [1:0] hp, sp;
    logic [3:0] ip;
    logic [2:0] ig;
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    sp = m_hist_p[upc[3:2]];
    upd_hist_p = sp;
    upd_hist_g = m_hist_g;
    hp = m_hist_p[ppc[3:2]];
    ip = {hp, ppc[3:2]};
    it.id = 0; it.tag = tag; it.exp_t = m_ctr_p[ip][1]; it.exp_h = {1'b0, hp};
    sb_q.push_back(it);
    ig = m_hist_g ^ {1'b0, ppc[3:2]};
    it.id = 1; it.tag = tag; it.exp_t = m_ctr_g[ig][1]; it.exp_h = m_hist_g;
    sb_q.push_back(it);
    #5 -> sample_ev;
    // model applies the update at the coming edge
    if (uv) begin
      ip = {sp, upc[3:2]};
      m_ctr_p[ip] = sat(m_ctr_p[ip], ut);
      m_hist_p[upc[3:2]] = {sp[0], ut};
      ig = m_hist_g ^ {1'b0, upc[3:2]};
      m_ctr_g[ig] = sat(m_ctr_g[ig], ut);
      m_hist_g = {m_hist_g[1:0], ut};
    end
  endtask

  // Monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic at;
        logic [2:0] ah;
        it = sb_q.pop_front();
        at = (it.id == 0) ? taken_p_o : taken_g_o;
        ah = (it.id == 0) ? {1'b0, hist_p_o} : hist_g_o;
        n_checks += 2;
        if (at !== it.exp_t) begin
          n_fail++;
          $display("FAIL %s dut%0d pred_taken actual=%b expected=%b", it.tag, it.id, at, it.exp_t);
        end
        if (ah !== it.exp_h) begin
          n_fail++;
          $display("FAIL %s dut%0d pred_hist actual=%b expected=%b", it.tag, it.id, ah, it.exp_h);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [31:0] PC_A = 32'h0000_1004; // pc[3:2]=01
  localparam logic [31:0] PC_B = 32'h0000_2008; // pc[3:2]=10
  localparam logic [31:0] PC_C = 32'h0000_300C; // pc[3:2]=11

  initial begin
    for (int i = 0; i < 4; i++) m_hist_p[i] = '0;
    for (int i = 0; i < 16; i++) m_ctr_p[i] = 2'd1;
    for (int i = 0; i < 8; i++) m_ctr_g[i] = 2'd1;
    m_hist_g = '0;
    pred_pc = '0; upd_pc = '0; upd_valid = 0; upd_taken = 0;
    upd_hist_p = '0; upd_hist_g = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state for several PCs
    step(PC_A, 0, PC_A, 0, "R1");
    step(PC_B, 0, PC_A, 0, "R1");
    step(PC_C, 0, PC_A, 0, "R1");

    // R2 R3 R5 R10: train A taken, predicting A in the same cycle
    for (int i = 0; i < 6; i++) step(PC_A, 1, PC_A, 1, "R3_R10");
    // R3 saturation: more taken at the saturated context
    for (int i = 0; i < 3; i++) step(PC_A, 1, PC_A, 1, "R3");
    step(PC_A, 0, PC_A, 0, "R2");

    // R4: alternate so the saturated context sees two not-taken updates
    step(PC_A, 1, PC_A, 0, "R4");
    step(PC_A, 1, PC_A, 1, "R4");
    step(PC_A, 1, PC_A, 1, "R4");
    step(PC_A, 0, PC_A, 0, "R4");
    step(PC_A, 1, PC_A, 0, "R4");
    step(PC_A, 1, PC_A, 1, "R4");
    step(PC_A, 1, PC_A, 1, "R4");
    step(PC_A, 0, PC_A, 0, "R4");

    // R6 R7 R8: updates to B while predicting A and C
    for (int i = 0; i < 4; i++) step(PC_A, 1, PC_B, i[0], "R7_R8");
    step(PC_C, 0, PC_B, 0, "R6");
    step(PC_B, 0, PC_B, 0, "R6");

    // R11: strobe low with changing payload
    for (int i = 0; i < 4; i++) step((i[0] ? PC_A : PC_B), 0, PC_C, 1, "R11");

    // R9: index forming across PCs after mixed training
    for (int i = 0; i < 8; i++) step((i[1] ? PC_C : PC_B), 1, PC_C, i[0] | i[2], "R9");
    for (int i = 0; i < 4; i++) step(PC_A, 0, PC_A, 0, "R9");
    step(PC_B, 0, PC_A, 0, "R9");
    step(PC_C, 0, PC_A, 0, "R9");

    @(negedge clk);
    finish_run();
  end
endmodule